// File: doc/BRIEF.md
# Peripheral Memory Transfer Engine

This block copies data between a wide central memory, whose words are 60 bits, and a narrow peripheral memory, whose words are 12 bits. It takes one command at a time. A command either reads central memory into the peripheral memory or writes peripheral memory out to central memory. Each of the two directions can move a single word or a counted block of words.

Every 60-bit central word corresponds to five consecutive 12-bit peripheral words, most significant slice first. The central address comes from an 18-bit address operand. Its top bit selects whether a 64-word-aligned base, taken from a relocation input, is added to the 17-bit offset below it.

Writes are checked against an externally supplied inclusive address window. Reads are never checked. Both memories are accessed through a request/acknowledge handshake. The engine shows `busy` while it works and ends every accepted command with a one-cycle `done`.

Top module: `pp_cm_xfer`

## Requirements
- R1: A command is accepted only when `cmd_valid` is high and the engine is idle. The opcode is decoded in octal: 60 reads one word, 61 reads a block, 62 writes one word, 63 writes a block. Any other opcode is ignored: `busy` stays low and no memory request is made.
- R2: When `cmd_a[17]` is 1, the central address is `{reloc, 6'b0}` plus the zero-extended `cmd_a[16:0]`. When `cmd_a[17]` is 0, the central address is `cmd_a[16:0]` zero-extended.
- R3: On a read, bits 59:48 of the central word go to the first peripheral location. Bits 47:36, 35:24, 23:12 and 11:0 go to the next four consecutive locations.
- R4: Single-word commands start at peripheral address `cmd_d` (zero-extended). Block commands start at `cmd_m` and transfer exactly `cmd_d` central words. The central address increases by one per word.
- R5: A block command with `cmd_d` = 0 issues no memory request. Its `done` is high in the cycle after acceptance.
- R6: Peripheral addresses are 12 bits and wrap, so address 0 follows 7777 octal.
- R7: On a write, the first of the five peripheral words read lands in bits 59:48 of the central word. Later words fill successively lower slices.
- R8: A central write whose address lies outside `[wlim_lo, wlim_hi]` is not issued, and `err` is set. The other words of the block still proceed. `err` holds until the next command is accepted, which clears it.
- R9: A request, together with its address, direction and write data, stays stable until its acknowledge. Only one memory is requested at a time.
- R10: `busy` is high from the cycle after acceptance through the `done` cycle. `done` lasts one cycle. Commands presented while busy are ignored.
- R11: Central reads are issued regardless of the write window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 6 | Opcode, octal 60 to 63 |
| cmd_d | input | DW | Peripheral start address for single-word commands, word count for block commands |
| cmd_m | input | PAW | Peripheral start address for block commands |
| cmd_a | input | 18 | Address operand; bit 17 selects relocation |
| reloc | input | CAW-6 | Relocation base in units of 64 words |
| wlim_lo | input | CAW | Lowest central address that may be written |
| wlim_hi | input | CAW | Highest central address that may be written |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | A write was suppressed by the window |
| cm_req | output | 1 | Central memory request |
| cm_we | output | 1 | Central memory write |
| cm_addr | output | CAW | Central memory address |
| cm_wdata | output | 5*PW | Central write data |
| cm_ack | input | 1 | Central acknowledge; read data valid |
| cm_rdata | input | 5*PW | Central read data |
| pp_req | output | 1 | Peripheral memory request |
| pp_we | output | 1 | Peripheral memory write |
| pp_addr | output | PAW | Peripheral memory address |
| pp_wdata | output | PW | Peripheral write data |
| pp_ack | input | 1 | Peripheral acknowledge; read data valid |
| pp_rdata | input | PW | Peripheral read data |

## Verification
`busy` is due in the cycle after the accepting edge. For a zero-count block, `done` is also due in that cycle. Otherwise `done` rises in the cycle after the final acknowledge, or after the final suppressed write.

The bench applies a command at a falling edge and samples `busy` at the next falling edge. It then steps falling edge by falling edge until `done` appears, and confirms that `done` and `busy` are both low one cycle later. Memory contents and the list of central writes are compared only after `done`. This keeps the checks independent of the acknowledge latency, which the bench varies from zero to three cycles.

// File: rtl/pp_cm_xfer.sv
module pp_cm_xfer #(
  parameter int CAW = 24,
  parameter int PAW = 12,
  parameter int PW  = 12,
  parameter int DW  = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic [5:0]           cmd_op,
  input  logic [DW-1:0]        cmd_d,
  input  logic [PAW-1:0]       cmd_m,
  input  logic [17:0]          cmd_a,
  input  logic [CAW-7:0]       reloc,
  input  logic [CAW-1:0]       wlim_lo,
  input  logic [CAW-1:0]       wlim_hi,
  output logic                 busy,
  output logic                 done,
  output logic                 err,
  output logic                 cm_req,
  output logic                 cm_we,
  output logic [CAW-1:0]       cm_addr,
  output logic [5*PW-1:0]      cm_wdata,
  input  logic                 cm_ack,
  input  logic [5*PW-1:0]      cm_rdata,
  output logic                 pp_req,
  output logic                 pp_we,
  output logic [PAW-1:0]       pp_addr,
  output logic [PW-1:0]        pp_wdata,
  input  logic                 pp_ack,
  input  logic [PW-1:0]        pp_rdata
);
  localparam int SLICES = 5;
  localparam int CW     = SLICES * PW;
  localparam int KW     = $clog2(SLICES);
  localparam int RW     = CAW - 6;

  typedef enum logic [2:0] {S_IDLE, S_CMRD, S_PPWR, S_PPRD, S_CMWR, S_FIN} st_t;

  st_t            st;
  logic [DW-1:0]  cnt;
  logic [PAW-1:0] ppa;
  logic [16:0]    off;
  logic           rel;
  logic [RW-1:0]  base;
  logic [CW-1:0]  sh;
  logic [KW-1:0]  k;

  wire op_ok    = cmd_op[5:2] == 4'b1100;
  wire accept   = cmd_valid && st == S_IDLE && op_ok;
  wire is_blk   = cmd_op[0];
  wire is_wr    = cmd_op[1];
  wire last_k   = k == KW'(SLICES - 1);
  wire last_w   = cnt == DW'(1);

  wire [CAW-1:0] abs_a = rel ? {base, 6'b0} + CAW'(off) : CAW'(off);
  wire           in_win = abs_a >= wlim_lo && abs_a <= wlim_hi;

  assign busy     = st != S_IDLE;
  assign done     = st == S_FIN;
  assign cm_req   = st == S_CMRD || (st == S_CMWR && in_win);
  assign cm_we    = st == S_CMWR;
  assign cm_addr  = abs_a;
  assign cm_wdata = sh;
  assign pp_req   = st == S_PPWR || st == S_PPRD;
  assign pp_we    = st == S_PPWR;
  assign pp_addr  = ppa;
  assign pp_wdata = sh[CW-1 -: PW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      err  <= 1'b0;
      cnt  <= '0;
      ppa  <= '0;
      off  <= '0;
      rel  <= 1'b0;
      base <= '0;
      sh   <= '0;
      k    <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          cnt  <= is_blk ? cmd_d : DW'(1);
          ppa  <= is_blk ? cmd_m : PAW'(cmd_d);
          off  <= cmd_a[16:0];
          rel  <= cmd_a[17];
          base <= reloc;
          err  <= 1'b0;
          k    <= '0;
          if (is_blk && cmd_d == '0) st <= S_FIN;
          else                       st <= is_wr ? S_PPRD : S_CMRD;
        end
        S_CMRD: if (cm_ack) begin
          sh <= cm_rdata;
          k  <= '0;
          st <= S_PPWR;
        end
        S_PPWR: if (pp_ack) begin
          sh  <= sh << PW;
          ppa <= ppa + 1'b1;
          k   <= k + 1'b1;
          if (last_k) begin
            k   <= '0;
            cnt <= cnt - 1'b1;
            off <= off + 1'b1;
            st  <= last_w ? S_FIN : S_CMRD;
          end
        end
        S_PPRD: if (pp_ack) begin
          sh  <= {sh[CW-PW-1:0], pp_rdata};
          ppa <= ppa + 1'b1;
          k   <= k + 1'b1;
          if (last_k) begin
            k  <= '0;
            st <= S_CMWR;
          end
        end
        S_CMWR: if (!in_win || cm_ack) begin
          if (!in_win) err <= 1'b1;
          cnt <= cnt - 1'b1;
          off <= off + 1'b1;
          st  <= last_w ? S_FIN : S_PPRD;
        end
        S_FIN:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pp_cm_xfer_chk.sv
module pp_cm_xfer_chk #(
  parameter int CAW = 24,
  parameter int PAW = 12,
  parameter int PW  = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic [CAW-1:0]  wlim_lo,
  input logic [CAW-1:0]  wlim_hi,
  input logic            busy,
  input logic            done,
  input logic            err,
  input logic            cm_req,
  input logic            cm_we,
  input logic [CAW-1:0]  cm_addr,
  input logic [5*PW-1:0] cm_wdata,
  input logic            cm_ack,
  input logic            pp_req,
  input logic            pp_we,
  input logic [PAW-1:0]  pp_addr,
  input logic [PW-1:0]   pp_wdata,
  input logic            pp_ack
);
  p_cm_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cm_req && !cm_ack |=> cm_req && $stable(cm_addr) && $stable(cm_we) && $stable(cm_wdata));

  p_pp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pp_req && !pp_ack |=> pp_req && $stable(pp_addr) && $stable(pp_we) && $stable(pp_wdata));

  p_one_port_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cm_req, pp_req}));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cm_req && !pp_req && !done);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  p_win_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cm_req && cm_we |-> cm_addr >= wlim_lo && cm_addr <= wlim_hi);

  p_err_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> busy);
endmodule

bind pp_cm_xfer pp_cm_xfer_chk #(.CAW(CAW), .PAW(PAW), .PW(PW)) u_chk (.*);

// File: tb/pp_cm_xfer_bench.sv
module pp_cm_xfer_bench;
  localparam int CAW = 24, PAW = 12, PW = 12, DW = 6;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0;
  logic [5:0] cmd_op = 0;
  logic [DW-1:0] cmd_d = 0;
  logic [PAW-1:0] cmd_m = 0;
  logic [17:0] cmd_a = 0;
  logic [CAW-7:0] reloc = 18'h2A5;
  logic [CAW-1:0] wlim_lo = 0, wlim_hi = '1;
  logic busy, done, err;
  logic cm_req, cm_we, cm_ack;
  logic [CAW-1:0] cm_addr;
  logic [59:0] cm_wdata, cm_rdata;
  logic pp_req, pp_we, pp_ack;
  logic [PAW-1:0] pp_addr;
  logic [PW-1:0] pp_wdata, pp_rdata;

  pp_cm_xfer u_pp_cm_xfer (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  int lat = 0;
  int n_cmr = 0, n_cmw = 0, n_pp = 0;
  logic [CAW-1:0] last_rd;
  logic [CAW-1:0] wa [$];
  logic [59:0]    wd [$];
  logic [11:0] ppm [4096];
  int cm_wait = 0, pp_wait = 0;
  logic [CAW-1:0] cm_a0;
  logic [PAW-1:0] pp_a0;
  bit finished = 0;

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [59:0] cmf(logic [23:0] a);
    return {a ^ 24'hA5C3F1, 12'h5A7, a};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      cm_ack <= 0; cm_wait = 0;
    end else if (cm_ack) begin
      cm_ack <= 0; cm_wait = 0;
    end else if (cm_req) begin
      if (cm_wait == 0) cm_a0 = cm_addr;
      if (cm_wait >= lat) begin
        chk(cm_addr == cm_a0, "R9", 64'(cm_addr), 64'(cm_a0));
        cm_ack <= 1;
        if (cm_we) begin wa.push_back(cm_addr); wd.push_back(cm_wdata); n_cmw++; end
        else begin cm_rdata <= cmf(cm_addr); last_rd = cm_addr; n_cmr++; end
      end else cm_wait++;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      pp_ack <= 0; pp_wait = 0;
    end else if (pp_ack) begin
      pp_ack <= 0; pp_wait = 0;
    end else if (pp_req) begin
      if (pp_wait == 0) pp_a0 = pp_addr;
      if (pp_wait >= lat) begin
        chk(pp_addr == pp_a0, "R9", 64'(pp_addr), 64'(pp_a0));
        pp_ack <= 1; n_pp++;
        if (pp_we) ppm[pp_addr] = pp_wdata;
        else pp_rdata <= ppm[pp_addr];
      end else pp_wait++;
    end
  end

  task automatic start(logic [5:0] op, logic [5:0] d, logic [11:0] m, logic [17:0] a);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_d = d; cmd_m = m; cmd_a = a;
    @(negedge clk);
    cmd_valid = 0;
    chk(busy == 1, "R10", 64'(busy), 1);
  endtask

  task automatic finish_cmd();
    int n = 0;
    while (!done && n < 3000) begin @(negedge clk); n++; end
    chk(done == 1, "R10", 64'(done), 1);
    @(negedge clk);
    chk(done == 0 && busy == 0, "R10", {done, busy}, 0);
  endtask

  task automatic t_reset();
    chk(busy == 0 && done == 0 && err == 0 && cm_req == 0 && pp_req == 0,
        "R10", {busy, done, err, cm_req, pp_req}, 0);
  endtask

  task automatic t_read_one();
    logic [59:0] w = cmf(24'o123);
    lat = 1;
    start(6'o60, 6'o10, 0, 18'o000123);
    finish_cmd();
    chk(last_rd == 24'o123, "R2", 64'(last_rd), 24'o123);
    for (int i = 0; i < 5; i++)
      chk(ppm[8 + i] == w[59 - 12*i -: 12], "R3", 64'(ppm[8 + i]), 64'(w[59 - 12*i -: 12]));
  endtask

  task automatic t_read_reloc();
    logic [17:0] a = {1'b1, 17'h1F0F0};
    logic [23:0] ex = {reloc, 6'b0} + 24'(a[16:0]);
    logic [59:0] w = cmf(ex);
    lat = 0;
    start(6'o60, 6'o40, 0, a);
    finish_cmd();
    chk(last_rd == ex, "R2", 64'(last_rd), 64'(ex));
    for (int i = 0; i < 5; i++)
      chk(ppm[32 + i] == w[59 - 12*i -: 12], "R2", 64'(ppm[32 + i]), 64'(w[59 - 12*i -: 12]));
  endtask

  task automatic t_read_block();
    int r0 = n_cmr;
    lat = 2;
    wlim_lo = 24'h900000; wlim_hi = 24'h900001;
    start(6'o61, 6'd3, 12'o7776, 18'o000700);
    finish_cmd();
    chk(n_cmr - r0 == 3, "R11", 64'(n_cmr - r0), 3);
    for (int wi = 0; wi < 3; wi++) begin
      logic [59:0] w = cmf(24'(24'o700 + wi));
      for (int i = 0; i < 5; i++) begin
        logic [11:0] pa = 12'(12'o7776 + 5*wi + i);
        chk(ppm[pa] == w[59 - 12*i -: 12], (pa < 12'o7776) ? "R6" : "R4",
            64'(ppm[pa]), 64'(w[59 - 12*i -: 12]));
      end
    end
    wlim_lo = 0; wlim_hi = '1;
  endtask

  task automatic t_write_one();
    for (int i = 0; i < 5; i++) ppm[16 + i] = 12'(12'h100 + i);
    wa.delete(); wd.delete();
    lat = 3;
    start(6'o62, 6'o20, 0, 18'o001000);
    finish_cmd();
    chk(wa.size() == 1, "R7", 64'(wa.size()), 1);
    if (wa.size() == 1) begin
      chk(wa[0] == 24'o1000, "R4", 64'(wa[0]), 24'o1000);
      chk(wd[0] == {12'h100, 12'h101, 12'h102, 12'h103, 12'h104}, "R7", wd[0],
          {12'h100, 12'h101, 12'h102, 12'h103, 12'h104});
    end
    chk(err == 0, "R8", 64'(err), 0);
  endtask

  task automatic t_write_window();
    for (int i = 0; i < 15; i++) ppm[12'h050 + i] = 12'(12'hA00 + i);
    wa.delete(); wd.delete();
    wlim_lo = 24'h300; wlim_hi = 24'h301;
    lat = 1;
    start(6'o63, 6'd3, 12'h050, 18'h00300);
    finish_cmd();
    chk(wa.size() == 2, "R8", 64'(wa.size()), 2);
    chk(err == 1, "R8", 64'(err), 1);
    for (int wi = 0; wi < 2 && wi < wa.size(); wi++) begin
      logic [59:0] ex;
      for (int i = 0; i < 5; i++) ex[59 - 12*i -: 12] = 12'(12'hA00 + 5*wi + i);
      chk(wa[wi] == 24'(24'h300 + wi), "R4", 64'(wa[wi]), 64'(24'h300 + wi));
      chk(wd[wi] == ex, "R7", wd[wi], ex);
    end
    wlim_lo = 0; wlim_hi = '1;
  endtask

  task automatic t_zero();
    int a0 = n_cmr + n_cmw + n_pp;
    @(negedge clk);
    cmd_valid = 1; cmd_op = 6'o61; cmd_d = 0; cmd_m = 12'h123; cmd_a = 0;
    @(negedge clk);
    cmd_valid = 0;
    chk(done == 1 && busy == 1, "R5", {done, busy}, 2'b11);
    chk(err == 0, "R8", 64'(err), 0);
    @(negedge clk);
    chk(done == 0 && busy == 0, "R5", {done, busy}, 0);
    chk(n_cmr + n_cmw + n_pp == a0, "R5", 64'(n_cmr + n_cmw + n_pp), 64'(a0));
  endtask

  task automatic t_bad_op();
    int a0 = n_cmr + n_cmw + n_pp;
    foreach (cmd_op[i]) ;
    @(negedge clk);
    cmd_valid = 1; cmd_op = 6'o57; cmd_d = 1; cmd_a = 0;
    @(negedge clk);
    cmd_op = 6'o64;
    @(negedge clk);
    cmd_valid = 0;
    chk(busy == 0, "R1", 64'(busy), 0);
    repeat (4) @(negedge clk);
    chk(busy == 0 && n_cmr + n_cmw + n_pp == a0, "R1", 64'(n_cmr + n_cmw + n_pp), 64'(a0));
  endtask

  task automatic t_busy_ignore();
    int r0 = n_cmr, w0 = n_cmw;
    lat = 2;
    start(6'o60, 6'o50, 0, 18'o5);
    cmd_valid = 1; cmd_op = 6'o62; cmd_d = 0; cmd_a = 18'o7;
    @(negedge clk);
    cmd_valid = 0;
    finish_cmd();
    repeat (3) @(negedge clk);
    chk(busy == 0, "R10", 64'(busy), 0);
    chk(n_cmr - r0 == 1 && n_cmw == w0, "R10", 64'(n_cmr - r0), 1);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R10 actual=running expected=finished");
    report();
  end

  initial begin
    for (int i = 0; i < 4096; i++) ppm[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_read_one();
    t_read_reloc();
    t_read_block();
    t_write_one();
    t_write_window();
    t_zero();
    t_bad_op();
    t_busy_ignore();
    report();
  end
endmodule